// File: doc/BRIEF.md
# PHY Management Register Engine

This block lets a host reach the registers of an external Ethernet PHY through one 32-bit command word. Writing the word starts a single management cycle on the two-wire serial management bus (MDC clock, bidirectional MDIO data). The opcode field selects read or write. The PHY address, the register number and, for writes, the 16-bit data sit in fixed fields of the same word. The host then polls the word. The ready flag rises when the serial cycle ends, and after a read the low half holds the value the PHY returned.

The engine has four parts: a command register, an MDC divider, a frame shifter and the turnaround control. The divider runs only while a cycle is in flight. The shifter sends a fixed-length frame with one bit per MDC period. Every change on the MDIO output is made on a falling MDC edge, and read data is sampled on rising edges. Every frame runs to its full length, and no PHY reply is needed for it to finish, so the ready flag always comes back.

Top module: `phy_mgmt_engine`

## Requirements
- R1: After reset the command word reads 0x1000_0000 (ready bit 28 set, every other bit 0), MDC is low and MDIO is not driven (`mdio_oe` = 0).
- R2: A host write while ready is set is accepted on that clock edge. It loads the opcode from bits 27:26, the PHY address from bits 25:21, the register number from bits 20:16 and the data from bits 15:0. From the next cycle the word reads back with ready (bit 28) clear and bits 31:29 always 0.
- R3: From the cycle after acceptance, MDIO is driven with the frame one bit per MDC period, MSB first: PRE_LEN ones (default 32), then 0, 1, the two opcode bits, the 5-bit PHY address and the 5-bit register number. `mdio_o` and `mdio_oe` change only when MDC falls.
- R4: MDC is low while idle and also at the start of a cycle. It toggles every MDC_HALF clocks during a cycle, and a cycle lasts exactly 2·MDC_HALF·(PRE_LEN+32) clocks after acceptance.
- R5: Any opcode other than 10 (01 = write, and also 00 and 11) is framed as a write: the bits after the register number are 1, 0, then the 16 data bits MSB first, all driven.
- R6: Opcode 10 (read) releases MDIO (`mdio_oe` = 0) for the two turnaround bits and the 16 data bits. It samples `mdio_i` on each of the 16 rising MDC edges of the data bits, MSB first, and places the result in bits 15:0 when the cycle completes.
- R7: In the final clock of a cycle, ready returns to 1 and MDIO is released. The opcode, address and register fields keep their values, and after a write the data field still holds the written data.
- R8: If no PHY answers a read (`mdio_i` held high), the cycle still completes with ready set and bits 15:0 equal to 0xFFFF.
- R9: A host write while a cycle is in flight changes nothing: the word keeps its fields, ready stays 0, and the frame on MDIO runs on unchanged.
- R10: A new command written in the first cycle in which ready reads 1 is accepted at once, with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Write strobe for the command word |
| host_wdata | input | 32 | Command word written by the host |
| host_rdata | output | 32 | Current command word: ready, fields, data |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (1 = drive) |
| mdio_i | input | 1 | MDIO input value from the pad |

## Verification
The hardest case to reach from the ports is a host write that lands while a read is in flight, especially in the cycle right after acceptance and in the completion cycle itself. The stimulus issues such writes at several fixed offsets inside a read. A cycle-accurate reference model then checks, on every clock, that the frame bits, the released turnaround and the captured data are unaffected. A back-to-back command written in the exact cycle ready returns covers the other edge of the same window. A read with the input held high shows that completion does not depend on any PHY reply.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

  localparam int unsigned CMD_W        = 32;
  localparam int unsigned DATA_W       = 16;
  localparam int unsigned ADDR_W       = 5;
  localparam int unsigned RDY_BIT      = 28;
  localparam int unsigned CMD_FIELDS_W = 2 + 2 * ADDR_W + DATA_W;

  typedef enum logic [1:0] {
    OP_RSVD_LO = 2'b00,
    OP_WRITE   = 2'b01,
    OP_READ    = 2'b10,
    OP_RSVD_HI = 2'b11
  } mgmt_op_e;

  // Packed so that the fields land on bits 27:26, 25:21, 20:16, 15:0.
  typedef struct packed {
    mgmt_op_e            op;
    logic [ADDR_W-1:0]   phy;
    logic [ADDR_W-1:0]   regn;
    logic [DATA_W-1:0]   data;
  } mgmt_cmd_t;

endpackage

// File: rtl/phy_mgmt_mdc_div.sv
module phy_mgmt_mdc_div #(
  parameter int unsigned HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_ev,
  output logic fall_ev
);

  localparam int unsigned CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             mdc_q, mdc_d;
  logic             wrap;

  always_comb begin
    wrap  = run && (cnt_q == CNT_LAST);
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (wrap) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc     = mdc_q;
  assign rise_ev = wrap && !mdc_q;
  assign fall_ev = wrap && mdc_q;

  // R4: the clock is parked low whenever no cycle runs
  assert_mdc_idle_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !mdc_q);

endmodule

// File: rtl/phy_mgmt_frame.sv
module phy_mgmt_frame
  import phy_mgmt_pkg::*;
#(
  parameter int unsigned PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  mgmt_cmd_t         cmd,
  input  logic              rise_ev,
  input  logic              fall_ev,
  input  logic              mdio_i,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              mdio_o,
  output logic              mdio_oe
);

  localparam int unsigned HDR_LEN   = PRE_LEN + 4 + 2 * ADDR_W;
  localparam int unsigned DATA_POS  = HDR_LEN + 2;
  localparam int unsigned FRAME_LEN = DATA_POS + DATA_W;
  localparam int unsigned BIT_W     = $clog2(FRAME_LEN);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_LEN - 1);
  localparam logic [BIT_W-1:0] HDR_END  = BIT_W'(HDR_LEN);
  localparam logic [BIT_W-1:0] DATA_BEG = BIT_W'(DATA_POS);

  logic                 busy_q, busy_d;
  logic                 rd_q, rd_d;
  logic [BIT_W-1:0]     bit_q, bit_d;
  logic [FRAME_LEN-1:0] sh_q, sh_d;
  logic [DATA_W-1:0]    cap_q, cap_d;
  logic [1:0]           ta_bits;
  logic [FRAME_LEN-1:0] frame_word;
  logic                 last_bit;

  always_comb begin
    ta_bits    = (cmd.op == OP_READ) ? 2'b11 : 2'b10;
    frame_word = {{PRE_LEN{1'b1}}, 2'b01, cmd.op, cmd.phy, cmd.regn, ta_bits, cmd.data};
    last_bit   = (bit_q == LAST_BIT);
  end

  always_comb begin
    busy_d = busy_q;
    rd_d   = rd_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    cap_d  = cap_q;
    if (start) begin
      busy_d = 1'b1;
      rd_d   = (cmd.op == OP_READ);
      bit_d  = '0;
      sh_d   = frame_word;
    end else if (busy_q) begin
      if (rise_ev && rd_q && (bit_q >= DATA_BEG)) begin
        cap_d = {cap_q[DATA_W-2:0], mdio_i};
      end
      if (fall_ev) begin
        if (last_bit) begin
          busy_d = 1'b0;
        end else begin
          bit_d = bit_q + BIT_W'(1);
          sh_d  = {sh_q[FRAME_LEN-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      bit_q  <= '0;
      sh_q   <= '0;
      cap_q  <= '0;
    end else begin
      busy_q <= busy_d;
      rd_q   <= rd_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      cap_q  <= cap_d;
    end
  end

  assign busy    = busy_q;
  assign done    = busy_q && fall_ev && last_bit;
  assign rdata   = cap_q;
  assign mdio_o  = sh_q[FRAME_LEN-1];
  assign mdio_oe = busy_q && !(rd_q && (bit_q >= HDR_END));

  // R3: the first preamble bit is on the wire right after acceptance
  assert_preamble_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (mdio_oe && mdio_o));

  // R3: the data pin moves only on a falling MDC edge
  assert_mdio_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !fall_ev && !start) |=> ($stable(mdio_o) && $stable(mdio_oe)));

  // R7: the pin is released once the final bit has gone
  assert_release_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy_q && !mdio_oe));

endmodule

// File: rtl/phy_mgmt_cmd_reg.sv
module phy_mgmt_cmd_reg
  import phy_mgmt_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [CMD_FIELDS_W-1:0] wr_fields,
  input  logic                    busy,
  input  logic                    done,
  input  logic [DATA_W-1:0]       rdata,
  output logic                    start,
  output mgmt_cmd_t               new_cmd,
  output mgmt_cmd_t               cmd,
  output logic                    ready
);

  mgmt_cmd_t cmd_q, cmd_d;
  logic      ready_q, ready_d;

  always_comb begin
    new_cmd = mgmt_cmd_t'(wr_fields);
    start   = wr_en && ready_q;
    cmd_d   = cmd_q;
    ready_d = ready_q;
    if (start) begin
      cmd_d   = new_cmd;
      ready_d = 1'b0;
    end else if (done) begin
      ready_d = 1'b1;
      if (cmd_q.op == OP_READ) begin
        cmd_d.data = rdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      ready_q <= 1'b1;
    end else begin
      cmd_q   <= cmd_d;
      ready_q <= ready_d;
    end
  end

  assign cmd   = cmd_q;
  assign ready = ready_q;

  // R7: the flag seen by the host mirrors the shifter being idle
  assert_ready_mirror_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q != busy);

  // R9: writes during a cycle leave the word untouched
  assert_busy_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && !done) |=> ($stable(cmd_q) && !ready_q));

endmodule

// File: rtl/phy_mgmt_engine.sv
module phy_mgmt_engine
  import phy_mgmt_pkg::*;
#(
  parameter int unsigned MDC_HALF = 2,
  parameter int unsigned PRE_LEN  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr,
  input  logic [CMD_W-1:0] host_wdata,
  output logic [CMD_W-1:0] host_rdata,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i
);

  localparam int unsigned PAD_W = CMD_W - CMD_FIELDS_W - 1;

  logic [1:0]        rst_sync_q;
  logic              rst_core_n;
  logic              start, busy, done, ready;
  logic              rise_ev, fall_ev;
  logic [DATA_W-1:0] rdata;
  mgmt_cmd_t         new_cmd, cmd;
  logic              unused_hi;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[1];

  assign unused_hi = ^host_wdata[CMD_W-1:CMD_FIELDS_W];

  phy_mgmt_cmd_reg u_cmd (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .wr_en     (host_wr),
    .wr_fields (host_wdata[CMD_FIELDS_W-1:0]),
    .busy      (busy),
    .done      (done),
    .rdata     (rdata),
    .start     (start),
    .new_cmd   (new_cmd),
    .cmd       (cmd),
    .ready     (ready)
  );

  phy_mgmt_mdc_div #(.HALF(MDC_HALF)) u_div (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .run     (busy),
    .mdc     (mdc),
    .rise_ev (rise_ev),
    .fall_ev (fall_ev)
  );

  phy_mgmt_frame #(.PRE_LEN(PRE_LEN)) u_frame (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .start   (start),
    .cmd     (new_cmd),
    .rise_ev (rise_ev),
    .fall_ev (fall_ev),
    .mdio_i  (mdio_i),
    .busy    (busy),
    .done    (done),
    .rdata   (rdata),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe)
  );

  assign host_rdata = {{PAD_W{1'b0}}, ready, cmd};

  // R6: during a read the data phase never drives the pin
  assert_read_data_released_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (busy && !ready && (cmd.op == OP_READ) && rise_ev && !mdio_oe) |=> !mdio_oe || !busy || fall_ev || $past(fall_ev));

endmodule

// File: tb/phy_mgmt_engine_tb.sv
module phy_mgmt_engine_tb;

  localparam int H   = 2;
  localparam int PRE = 32;
  localparam int NB  = PRE + 32;
  localparam int HDR = PRE + 14;
  localparam int DBG = PRE + 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_wr;
  logic [31:0] host_wdata;
  logic [31:0] host_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  int    checks = 0;
  int    fails  = 0;
  bit    m_busy;
  bit    m_rd;
  int    t;
  logic [31:0] m_reg;
  logic [15:0] m_cap;
  logic [15:0] phy_val;
  bit    phy_absent;
  bit    m_frame[$];
  string cur_req;

  always #4 clk = ~clk;

  phy_mgmt_engine #(.MDC_HALF(H), .PRE_LEN(PRE)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic build_frame(input logic [31:0] d);
    m_frame.delete();
    repeat (PRE) m_frame.push_back(1'b1);
    m_frame.push_back(1'b0);
    m_frame.push_back(1'b1);
    for (int i = 1; i >= 0; i--) m_frame.push_back(d[26+i]);
    for (int i = 4; i >= 0; i--) m_frame.push_back(d[21+i]);
    for (int i = 4; i >= 0; i--) m_frame.push_back(d[16+i]);
    m_frame.push_back(1'b1);
    m_frame.push_back(d[27:26] == 2'b10);
    for (int i = 15; i >= 0; i--) m_frame.push_back(d[i]);
  endtask

  task automatic compare();
    int    idx;
    bit    e_mdc, e_oe;
    string tag;
    idx   = t / (2 * H);
    e_mdc = m_busy ? (((t / H) % 2) == 1) : 1'b0;
    e_oe  = m_busy && !(m_rd && idx >= HDR);
    tag   = (idx < HDR) ? "R3" : (m_rd ? "R6" : "R5");
    chk(host_rdata === m_reg, cur_req, "host_rdata", host_rdata, m_reg);
    chk(mdc === e_mdc, "R4", "mdc", {31'd0, mdc}, {31'd0, e_mdc});
    chk(mdio_oe === e_oe, tag, "mdio_oe", {31'd0, mdio_oe}, {31'd0, e_oe});
    if (e_oe)
      chk(mdio_o === m_frame[idx], tag, "mdio_o", {31'd0, mdio_o}, {31'd0, m_frame[idx]});
  endtask

  task automatic drive_phy();
    int idx;
    idx = t / (2 * H);
    if (phy_absent || !m_busy || !m_rd) mdio_i = 1'b1;
    else if (idx >= DBG) mdio_i = phy_val[15 - (idx - DBG)];
    else if (idx == DBG - 1) mdio_i = 1'b0;
    else mdio_i = 1'b1;
  endtask

  task automatic tick(input bit en, input logic [31:0] d);
    host_wr    = en;
    host_wdata = d;
    if (m_busy) begin
      t++;
      if ((t % H) == 0 && ((t / H) % 2) == 1 && m_rd && (t / (2 * H)) >= DBG)
        m_cap = {m_cap[14:0], mdio_i};
      if (t == 2 * H * NB) begin
        m_busy    = 1'b0;
        m_reg[28] = 1'b1;
        if (m_rd) m_reg[15:0] = m_cap;
      end
    end else if (en) begin
      m_busy = 1'b1;
      t      = 0;
      m_reg  = {4'b0000, d[27:0]};
      m_rd   = (d[27:26] == 2'b10);
      build_frame(d);
    end
    @(negedge clk);
    host_wr = 1'b0;
    compare();
    drive_phy();
  endtask

  task automatic finish_cycle();
    while (m_busy) tick(1'b0, 32'd0);
    tick(1'b0, 32'd0);
  endtask

  function automatic logic [31:0] mk(input logic [1:0] op, input logic [4:0] ph,
                                      input logic [4:0] rg, input logic [15:0] dt);
    return {4'b0000, op, ph, rg, dt};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    host_wr = 1'b0; host_wdata = 32'd0; mdio_i = 1'b1; rst_n = 1'b0;
    m_busy = 1'b0; m_rd = 1'b0; t = 0; m_cap = 16'd0; phy_val = 16'd0;
    phy_absent = 1'b0; m_reg = 32'h1000_0000; cur_req = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) tick(1'b0, 32'd0);
    chk(host_rdata === 32'h1000_0000 && mdc === 1'b0 && mdio_oe === 1'b0,
        "R1", "reset state", host_rdata, 32'h1000_0000);

    // R2 / R5: write frame, field load
    cur_req = "R2";
    tick(1'b1, mk(2'b01, 5'h15, 5'h0A, 16'hA5C3));
    chk(host_rdata === 32'h0000_0000 | mk(2'b01, 5'h15, 5'h0A, 16'hA5C3),
        "R2", "fields after accept", host_rdata, mk(2'b01, 5'h15, 5'h0A, 16'hA5C3));
    finish_cycle();
    chk(host_rdata === (32'h1000_0000 | mk(2'b01, 5'h15, 5'h0A, 16'hA5C3)),
        "R7", "write complete", host_rdata, 32'h1000_0000 | mk(2'b01, 5'h15, 5'h0A, 16'hA5C3));

    // R6: read returning a value
    cur_req = "R6";
    phy_val = 16'h1234;
    tick(1'b1, mk(2'b10, 5'h01, 5'h02, 16'h0000));
    finish_cycle();
    chk(host_rdata[15:0] === 16'h1234 && host_rdata[28] === 1'b1,
        "R6", "read data", host_rdata, 32'h1000_0000 | mk(2'b10, 5'h01, 5'h02, 16'h1234));

    // R9: writes during a read are dropped
    cur_req = "R9";
    phy_val = 16'h8001;
    tick(1'b1, mk(2'b10, 5'h03, 5'h1F, 16'h0000));
    tick(1'b1, mk(2'b01, 5'h1E, 5'h05, 16'hDEAD));
    chk(host_rdata === mk(2'b10, 5'h03, 5'h1F, 16'h0000),
        "R9", "write after accept ignored", host_rdata, mk(2'b10, 5'h03, 5'h1F, 16'h0000));
    repeat (40) tick(1'b0, 32'd0);
    tick(1'b1, mk(2'b01, 5'h00, 5'h00, 16'hFFFF));
    repeat (150) tick(1'b0, 32'd0);
    tick(1'b1, mk(2'b10, 5'h07, 5'h07, 16'h5555));
    chk(host_rdata[28] === 1'b0 && host_rdata[25:21] === 5'h03,
        "R9", "ready low during cycle", host_rdata, mk(2'b10, 5'h03, 5'h1F, 16'h0000));
    while (m_busy && t < 2 * H * NB - 1) tick(1'b0, 32'd0);
    tick(1'b1, mk(2'b01, 5'h09, 5'h09, 16'h9999));
    tick(1'b0, 32'd0);
    chk(host_rdata === (32'h1000_0000 | mk(2'b10, 5'h03, 5'h1F, 16'h8001)),
        "R9", "write on completion edge ignored", host_rdata,
        32'h1000_0000 | mk(2'b10, 5'h03, 5'h1F, 16'h8001));

    // R8: no PHY answering
    cur_req = "R8";
    phy_absent = 1'b1;
    tick(1'b1, mk(2'b10, 5'h11, 5'h03, 16'h0000));
    finish_cycle();
    chk(host_rdata === (32'h1000_0000 | mk(2'b10, 5'h11, 5'h03, 16'hFFFF)),
        "R8", "absent phy", host_rdata, 32'h1000_0000 | mk(2'b10, 5'h11, 5'h03, 16'hFFFF));
    phy_absent = 1'b0;

    // R5 / R2: reserved opcodes framed as writes, top bits read zero
    cur_req = "R5";
    tick(1'b1, 32'hE000_0000 | mk(2'b11, 5'h0F, 5'h10, 16'h0F0F));
    chk(host_rdata[31:29] === 3'b000, "R2", "upper bits zero", host_rdata,
        mk(2'b11, 5'h0F, 5'h10, 16'h0F0F));
    finish_cycle();
    tick(1'b1, mk(2'b00, 5'h1F, 5'h1F, 16'h8000));
    finish_cycle();
    chk(host_rdata === (32'h1000_0000 | mk(2'b00, 5'h1F, 5'h1F, 16'h8000)),
        "R5", "opcode 00 write", host_rdata, 32'h1000_0000 | mk(2'b00, 5'h1F, 5'h1F, 16'h8000));

    // R10: back-to-back acceptance
    cur_req = "R10";
    phy_val = 16'hC3A5;
    tick(1'b1, mk(2'b01, 5'h02, 5'h04, 16'h1111));
    while (m_busy) tick(1'b0, 32'd0);
    chk(host_rdata[28] === 1'b1, "R10", "ready returned", host_rdata, m_reg);
    tick(1'b1, mk(2'b10, 5'h02, 5'h04, 16'h0000));
    chk(host_rdata[28] === 1'b0 && mdio_oe === 1'b1, "R10", "immediate accept",
        host_rdata, mk(2'b10, 5'h02, 5'h04, 16'h0000));
    finish_cycle();
    chk(host_rdata[15:0] === 16'hC3A5, "R10", "second read data", host_rdata,
        32'h1000_0000 | mk(2'b10, 5'h02, 5'h04, 16'hC3A5));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule